// File: doc/BRIEF.md
# Per-Line Vectored Interrupt Arbiter

This block gathers interrupt requests from up to `NUM_LINES` serial terminal lines into two groups, one for receive and one for transmit. Each line owns one pending bit in each group. A group's master request output is high while any of its pending bits is set. When the bus acknowledges a group, the block presents the vector of the lowest-numbered pending line in that group and clears that line's bit on the acknowledge edge.

The surrounding register logic supplies events rather than register contents. It reports a done flag becoming set, a write to the interrupt-enable bit (with the written value and the current done and enable levels), a done flag being cleared, and a per-line reset. From a single base vector the block derives every line's vector. A line's receive vector is the base plus eight times the line number. Its transmit vector is four above that.

The vector output is combinational. It is valid during the cycle in which the acknowledge input is high. The pending bit is removed at the clock edge that ends that cycle.

Top module: `intr_vec_arb`

## Requirements
- R1: Receive and transmit pending bits are held per line in two independent vectors. An event on one group never changes the other group.
- R2: `rx_req_o` / `tx_req_o` is high exactly while at least one pending bit of that group is set. After reset both are low and no bit is pending.
- R3: While an acknowledge is high, the group serves the lowest-numbered pending line. At that edge only this line's bit is cleared, and every other pending bit is kept.
- R4: The receive vector for line n is `base_vec_i + 8*n`. The transmit vector for line n is `base_vec_i + 8*n + 4`.
- R5: A done event on a line whose enable input is high sets that line's pending bit. With enable low, a done event sets nothing.
- R6: An enable write of 1 sets the pending bit only if done is high and enable was low. An enable write of 0 clears the line's pending bit.
- R7: A done-clear strobe clears that line's pending bit in its group. A bit in `line_rst_i` clears both of that line's pending bits.
- R8: An acknowledge with nothing pending yields vector 0 and changes no state.
- R9: If a set and a clear of the same bit coincide, the clear wins. An acknowledge and a new request on another line in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_vec_i | input | VEC_W | Base interrupt vector |
| line_rst_i | input | NUM_LINES | Per-line reset strobes, clear both groups |
| rx_done_ev_i | input | NUM_LINES | Receive done became set |
| rx_ie_i | input | NUM_LINES | Current receive enable levels |
| rx_done_i | input | NUM_LINES | Current receive done levels |
| rx_ie_wr_i | input | NUM_LINES | Receive enable write strobes |
| rx_ie_wdata_i | input | NUM_LINES | Value written to receive enable |
| rx_done_clr_i | input | NUM_LINES | Receive done cleared |
| rx_ack_i | input | 1 | Bus acknowledge, receive group |
| rx_req_o | output | 1 | Receive group master request |
| rx_vec_o | output | VEC_W | Receive vector, 0 if none pending |
| tx_done_ev_i | input | NUM_LINES | Transmit done became set |
| tx_ie_i | input | NUM_LINES | Current transmit enable levels |
| tx_done_i | input | NUM_LINES | Current transmit done levels |
| tx_ie_wr_i | input | NUM_LINES | Transmit enable write strobes |
| tx_ie_wdata_i | input | NUM_LINES | Value written to transmit enable |
| tx_done_clr_i | input | NUM_LINES | Transmit done cleared |
| tx_ack_i | input | 1 | Bus acknowledge, transmit group |
| tx_req_o | output | 1 | Transmit group master request |
| tx_vec_o | output | VEC_W | Transmit vector, 0 if none pending |

## Verification
The bench reads back pending state through acknowledges alone. It acknowledges a group until the vector returns 0, and the order of the vectors shows the arbitration order and which bits survived.

- A design that served the highest line first, or cleared more than one bit per acknowledge, would return a different sequence.
- A design that dropped the +4 offset would alias transmit onto receive vectors.
- A design that re-raised on an enable write while enable was already set would return an extra vector.
- A design that let a set beat a coincident clear, or lost a new request raised in an acknowledge cycle, would leave an extra or missing vector in the final drain.
- A design that changed state on an idle acknowledge would return a vector where 0 is expected.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int unsigned VEC_STRIDE_SHIFT = 3;  // 8 vector bytes per line
  localparam int unsigned TX_VEC_OFS       = 4;
  localparam int unsigned RX_VEC_OFS       = 0;
endpackage

// File: rtl/intr_lowest_pick.sv
module intr_lowest_pick #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LN_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] gnt_o,
  output logic [LN_W-1:0]      idx_o,
  output logic                 any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = LN_W'(i);
      end
    end
  end

  assign any_o = |req_i;

  always_comb begin
    a_r3_grant_onehot: assert ($onehot0(gnt_o));
    a_r3_grant_subset: assert ((gnt_o & ~req_i) == '0);
  end
endmodule

// File: rtl/intr_req_group.sv
module intr_req_group #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned VEC_W     = 9,
  parameter int unsigned VEC_OFS   = 0,
  localparam int unsigned LN_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [VEC_W-1:0]     base_vec_i,
  input  logic [NUM_LINES-1:0] line_rst_i,
  input  logic [NUM_LINES-1:0] done_ev_i,
  input  logic [NUM_LINES-1:0] ie_i,
  input  logic [NUM_LINES-1:0] done_i,
  input  logic [NUM_LINES-1:0] ie_wr_i,
  input  logic [NUM_LINES-1:0] ie_wdata_i,
  input  logic [NUM_LINES-1:0] done_clr_i,
  input  logic                 ack_i,
  output logic                 req_o,
  output logic [VEC_W-1:0]     vec_o
);
  import intr_arb_pkg::*;

  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] set_v, clr_ext, clr_v, gnt;
  logic [LN_W-1:0]      win_idx;
  logic                 any_pend;

  intr_lowest_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .req_i (pend_q),
    .gnt_o (gnt),
    .idx_o (win_idx),
    .any_o (any_pend)
  );

  // enable write only raises on a 0->1 change of enable with done already set
  assign set_v   = (done_ev_i & ie_i) | (ie_wr_i & ie_wdata_i & done_i & ~ie_i);
  assign clr_ext = (ie_wr_i & ~ie_wdata_i) | done_clr_i | line_rst_i;
  assign clr_v   = clr_ext | (ack_i ? gnt : '0);
  assign pend_d  = (pend_q | set_v) & ~clr_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign req_o = any_pend;
  assign vec_o = any_pend
               ? base_vec_i + (VEC_W'(win_idx) << VEC_STRIDE_SHIFT) + VEC_W'(VEC_OFS)
               : '0;

  a_r3_one_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && set_v == '0 && clr_ext == '0)
      |=> ($countones(pend_q) + 1 == $countones($past(pend_q))));

  a_r3_winner_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o) |=> ((pend_q & $past(gnt)) == '0));

  a_r8_idle_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o) |-> (vec_o == '0));

  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && set_v == '0) |=> (pend_q == '0));

  a_r7_line_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_rst_i != '0) |=> ((pend_q & $past(line_rst_i)) == '0));

  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_v & clr_ext) != '0) |=> ((pend_q & $past(set_v & clr_ext)) == '0));
endmodule

// File: rtl/intr_vec_arb.sv
module intr_vec_arb #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned VEC_W     = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [VEC_W-1:0]     base_vec_i,
  input  logic [NUM_LINES-1:0] line_rst_i,
  input  logic [NUM_LINES-1:0] rx_done_ev_i,
  input  logic [NUM_LINES-1:0] rx_ie_i,
  input  logic [NUM_LINES-1:0] rx_done_i,
  input  logic [NUM_LINES-1:0] rx_ie_wr_i,
  input  logic [NUM_LINES-1:0] rx_ie_wdata_i,
  input  logic [NUM_LINES-1:0] rx_done_clr_i,
  input  logic                 rx_ack_i,
  output logic                 rx_req_o,
  output logic [VEC_W-1:0]     rx_vec_o,
  input  logic [NUM_LINES-1:0] tx_done_ev_i,
  input  logic [NUM_LINES-1:0] tx_ie_i,
  input  logic [NUM_LINES-1:0] tx_done_i,
  input  logic [NUM_LINES-1:0] tx_ie_wr_i,
  input  logic [NUM_LINES-1:0] tx_ie_wdata_i,
  input  logic [NUM_LINES-1:0] tx_done_clr_i,
  input  logic                 tx_ack_i,
  output logic                 tx_req_o,
  output logic [VEC_W-1:0]     tx_vec_o
);
  import intr_arb_pkg::*;

  intr_req_group #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .VEC_OFS   (RX_VEC_OFS)
  ) u_rx_grp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_vec_i (base_vec_i),
    .line_rst_i (line_rst_i),
    .done_ev_i  (rx_done_ev_i),
    .ie_i       (rx_ie_i),
    .done_i     (rx_done_i),
    .ie_wr_i    (rx_ie_wr_i),
    .ie_wdata_i (rx_ie_wdata_i),
    .done_clr_i (rx_done_clr_i),
    .ack_i      (rx_ack_i),
    .req_o      (rx_req_o),
    .vec_o      (rx_vec_o)
  );

  intr_req_group #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .VEC_OFS   (TX_VEC_OFS)
  ) u_tx_grp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_vec_i (base_vec_i),
    .line_rst_i (line_rst_i),
    .done_ev_i  (tx_done_ev_i),
    .ie_i       (tx_ie_i),
    .done_i     (tx_done_i),
    .ie_wr_i    (tx_ie_wr_i),
    .ie_wdata_i (tx_ie_wdata_i),
    .done_clr_i (tx_done_clr_i),
    .ack_i      (tx_ack_i),
    .req_o      (tx_req_o),
    .vec_o      (tx_vec_o)
  );

  // rx and tx offsets must not collide within one line's slot
  a_r4_vec_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_req_o && tx_req_o) |-> (rx_vec_o != tx_vec_o));
endmodule

// File: tb/intr_vec_arb_bench.sv
module intr_vec_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int VW = 9;
  localparam logic [VW-1:0] BASE = 9'h0C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0] base_vec = BASE;
  logic [N-1:0] line_rst = '0;
  logic [N-1:0] rx_ev = '0, rx_ie = '0, rx_done = '0, rx_wr = '0, rx_wd = '0, rx_clr = '0;
  logic [N-1:0] tx_ev = '0, tx_ie = '0, tx_done = '0, tx_wr = '0, tx_wd = '0, tx_clr = '0;
  logic rx_ack = 1'b0, tx_ack = 1'b0;
  logic rx_req, tx_req;
  logic [VW-1:0] rx_vec, tx_vec;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_vec_arb #(.NUM_LINES(N), .VEC_W(VW)) u_intr_vec_arb (
    .clk_i(clk), .rst_ni(rst_n), .base_vec_i(base_vec), .line_rst_i(line_rst),
    .rx_done_ev_i(rx_ev), .rx_ie_i(rx_ie), .rx_done_i(rx_done), .rx_ie_wr_i(rx_wr),
    .rx_ie_wdata_i(rx_wd), .rx_done_clr_i(rx_clr), .rx_ack_i(rx_ack),
    .rx_req_o(rx_req), .rx_vec_o(rx_vec),
    .tx_done_ev_i(tx_ev), .tx_ie_i(tx_ie), .tx_done_i(tx_done), .tx_ie_wr_i(tx_wr),
    .tx_ie_wdata_i(tx_wd), .tx_done_clr_i(tx_clr), .tx_ack_i(tx_ack),
    .tx_req_o(tx_req), .tx_vec_o(tx_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] vec_of(input bit is_tx, input int ln);
    return BASE + VW'(ln * 8) + (is_tx ? VW'(4) : VW'(0));
  endfunction

  // apply whatever strobes the caller set, for one edge, then clear them
  task automatic strobe();
    @(posedge clk); #1;
    rx_ev = '0; rx_wr = '0; rx_wd = '0; rx_clr = '0;
    tx_ev = '0; tx_wr = '0; tx_wd = '0; tx_clr = '0;
    line_rst = '0; rx_ack = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic ack_one(input bit is_tx, input logic [VW-1:0] exp, input string req);
    @(negedge clk);
    if (is_tx) tx_ack = 1'b1; else rx_ack = 1'b1;
    #1;
    chk(req, is_tx ? tx_vec : rx_vec, exp);
    strobe();
  endtask

  // acknowledge until empty; order of vectors exposes pending state
  task automatic drain(input bit is_tx, input logic [N-1:0] exp, input string req);
    for (int ln = 0; ln < N; ln++)
      if (exp[ln]) ack_one(is_tx, vec_of(is_tx, ln), req);
    ack_one(is_tx, '0, req);
    chk({req, " req low after drain"}, is_tx ? tx_req : rx_req, 0);
  endtask

  task automatic raise(input bit is_tx, input logic [N-1:0] lines);
    @(negedge clk);
    if (is_tx) begin tx_ie = lines; tx_ev = lines; end
    else       begin rx_ie = lines; rx_ev = lines; end
    strobe();
    rx_ie = '0; tx_ie = '0;
  endtask

  task automatic t_reset();
    chk("R2 reset rx_req", rx_req, 0);
    chk("R2 reset tx_req", tx_req, 0);
    chk("R8 reset rx_vec", rx_vec, 0);
  endtask

  task automatic t_done_events();
    @(negedge clk);
    rx_ie = 16'h0208; rx_ev = 16'h0228;   // line 5 event with enable low
    strobe();
    rx_ie = '0;
    chk("R2 rx_req raised", rx_req, 1);
    chk("R1 tx untouched", tx_req, 0);
    raise(1'b1, 16'h8001);
    chk("R2 tx_req raised", tx_req, 1);
    drain(1'b0, 16'h0208, "R3 R5 rx lowest first");
    drain(1'b1, 16'h8001, "R4 tx vectors");
  endtask

  task automatic t_enable_write();
    @(negedge clk);
    rx_done = 16'h0044; rx_ie = 16'h0040;
    rx_wr = 16'h0054; rx_wd = 16'h0054;   // line 2 raises; 4 no done; 6 already enabled
    strobe();
    rx_done = '0; rx_ie = '0;
    drain(1'b0, 16'h0004, "R6 enable write raise");
    raise(1'b0, 16'h0080);
    @(negedge clk);
    rx_wr = 16'h0080; rx_wd = '0;
    strobe();
    chk("R6 withdraw req", rx_req, 0);
    drain(1'b0, 16'h0000, "R6 withdraw");
  endtask

  task automatic t_line_reset();
    raise(1'b0, 16'h0102);
    raise(1'b1, 16'h0102);
    @(negedge clk);
    line_rst = 16'h0100;
    strobe();
    drain(1'b0, 16'h0002, "R7 line reset rx");
    drain(1'b1, 16'h0002, "R7 line reset tx");
    raise(1'b1, 16'h0030);
    @(negedge clk);
    tx_clr = 16'h0010;
    strobe();
    drain(1'b1, 16'h0020, "R7 done clear");
  endtask

  task automatic t_idle_ack();
    ack_one(1'b0, '0, "R8 idle rx ack");
    chk("R8 idle rx req", rx_req, 0);
    raise(1'b0, 16'h1000);
    ack_one(1'b1, '0, "R8 idle tx ack");
    drain(1'b0, 16'h1000, "R8 rx kept across tx idle ack");
  endtask

  task automatic t_coincide();
    @(negedge clk);
    rx_ie = 16'h0C00; rx_ev = 16'h0C00; rx_clr = 16'h0400;
    strobe();
    rx_ie = '0;
    drain(1'b0, 16'h0800, "R9 clear beats set");
    raise(1'b0, 16'h0010);
    @(negedge clk);
    rx_ack = 1'b1; rx_ie = 16'h0002; rx_ev = 16'h0002;
    #1 chk("R9 vec in ack+set cycle", rx_vec, vec_of(1'b0, 4));
    strobe();
    rx_ie = '0;
    drain(1'b0, 16'h0002, "R9 ack and new request");
    raise(1'b0, 16'h0020);
    @(negedge clk);
    rx_ack = 1'b1; rx_ie = 16'h0020; rx_ev = 16'h0020;
    strobe();
    rx_ie = '0;
    drain(1'b0, 16'h0000, "R9 ack beats set on winner");
  endtask

  task automatic t_single_clear();
    raise(1'b0, 16'h0007);
    ack_one(1'b0, vec_of(1'b0, 0), "R3 first of three");
    chk("R3 req still high", rx_req, 1);
    drain(1'b0, 16'h0006, "R3 others kept");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_done_events();
    t_enable_write();
    t_line_reset();
    t_idle_ack();
    t_coincide();
    t_single_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule